// File: doc/BRIEF.md
# Program Counter with Conditional Branch Resolution

This block keeps the 16-bit instruction address of a small 8-bit processor as a high byte and a low byte. On each step strobe it either moves forward by the instruction length the decoder reports, loads a jump target, returns to a saved address, or enters a halted state. The jump target comes either from a pair of register bytes or from a 16-bit immediate value. Whether a jump is taken depends on a 3-bit condition code tested against the status byte.

A taken jump stores the address of the following instruction in a one-entry return register, and a return strobe loads the counter from it. A halt strobe freezes the counter and the return register until reset. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the counter first reacts to a step on the third rising edge after reset goes high.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is active, and after it is released, the counter reads 0000h, the halted output is 0 and the return register holds 0000h. This is true even if step was high during reset.
- R2: A step with no jump, return or halt adds the length input (0 to 3) to the counter. A carry out of the low byte is added into the high byte.
- R3: The counter wraps from FFFFh or FFFEh through 0000h. The result is the 16-bit sum modulo 65536.
- R4: With step low, the counter and the return register stay unchanged, whatever the jump, return, halt and length inputs are.
- R5: Condition code 0 always passes. Codes 1 to 7 test status bits 7 to 1 in that order (code k tests bit 8-k): carry, overflow, zero, negative, greater, less, input-ready.
- R6: A taken jump loads the target. With target select 0 the target is {pair_hi_i, pair_lo_i}. With target select 1 it is imm_i.
- R7: A jump whose condition bit is 0 advances the counter by the length input, and the return register does not change.
- R8: A taken jump saves the counter plus the length input in the return register. A stepped return loads the counter from that register.
- R9: A stepped halt sets halted_o and keeps the counter as it is. After that, no step, jump or return changes the counter until reset.
- R10: Within one step the priority is halt first, then return, then jump. A lower-priority request made in the same step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance strobe, one per instruction |
| len_i | input | LEN_W | Instruction length in bytes |
| jmp_i | input | 1 | Jump request |
| cond_i | input | COND_W | Condition code |
| tgt_imm_i | input | 1 | Target select: 0 register pair, 1 immediate |
| pair_hi_i | input | BYTE_W | Register pair high byte |
| pair_lo_i | input | BYTE_W | Register pair low byte |
| imm_i | input | 2*BYTE_W | Immediate jump target |
| status_i | input | STAT_W | Status flags byte |
| ret_i | input | 1 | Return request |
| hlt_i | input | 1 | Halt request |
| pc_hi_o | output | BYTE_W | Counter high byte |
| pc_lo_o | output | BYTE_W | Counter low byte |
| halted_o | output | 1 | Halted state |

## Verification
The hardest state to set up is one where the return register holds a value that only a specific earlier jump could have produced. The stimulus therefore places several untaken jumps between a taken jump and the next return, and then checks that the return restores the address saved by the taken jump. The carry into the high byte and the wrap at the top of the address space are reached by jumping to addresses close to FFh and FFFFh and then stepping past them. Halt is applied last, together with a jump, and is followed by step, return and jump requests that must all have no effect.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int PC_BYTES = 2;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SEQ  = 2'd1,
    SRC_JUMP = 2'd2,
    SRC_RET  = 2'd3
  } pc_src_e;

endpackage

// File: rtl/pcb_rst_sync.sv
module pcb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcb_cond_eval.sv
module pcb_cond_eval #(
  parameter int COND_W = 3,
  parameter int STAT_W = 8
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              taken_o
);

  localparam int NCOND = 1 << COND_W;

  logic [NCOND-1:0] hit;

  // code 0 always passes; code k tests status bit STAT_W-k
  for (genvar gk = 0; gk < NCOND; gk++) begin : g_cond
    if (gk == 0) begin : g_always
      assign hit[gk] = 1'b1;
    end else begin : g_flag
      assign hit[gk] = status_i[STAT_W-gk];
    end
  end

  assign taken_o = hit[cond_i];

endmodule

// File: rtl/pcb_pc_reg.sv
module pcb_pc_reg
  import pcb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  pc_src_e                      src_i,
  input  logic [LEN_W-1:0]             len_i,
  input  logic [PC_BYTES*BYTE_W-1:0]   jump_tgt_i,
  input  logic [PC_BYTES*BYTE_W-1:0]   ret_addr_i,
  output logic [PC_BYTES*BYTE_W-1:0]   pc_o,
  output logic [PC_BYTES*BYTE_W-1:0]   seq_next_o
);

  localparam int PC_W = PC_BYTES * BYTE_W;

  logic [PC_BYTES-1:0][BYTE_W-1:0] pc_q;
  logic [PC_BYTES-1:0][BYTE_W-1:0] seq_b;
  logic [PC_BYTES-1:0]             carry;
  logic [PC_W-1:0]                 pc_d;
  logic                            pc_en;

  assign carry[0] = 1'b0;

  // byte-slice incrementer: each byte adds the carry out of the one below
  for (genvar gi = 0; gi < PC_BYTES; gi++) begin : g_byte
    logic [BYTE_W-1:0] addend;
    if (gi == 0) begin : g_low
      assign addend = BYTE_W'(len_i);
    end else begin : g_upper
      assign addend = '0;
    end
    if (gi < PC_BYTES - 1) begin : g_carry
      logic [BYTE_W:0] sum;
      assign sum = {1'b0, pc_q[gi]} + {1'b0, addend} + (BYTE_W+1)'(carry[gi]);
      assign seq_b[gi]    = sum[BYTE_W-1:0];
      assign carry[gi+1]  = sum[BYTE_W];
    end else begin : g_top
      assign seq_b[gi] = pc_q[gi] + addend + BYTE_W'(carry[gi]);
    end
  end

  assign seq_next_o = seq_b;
  assign pc_o       = pc_q;

  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q;
    case (src_i)
      SRC_SEQ:  pc_d = seq_b;
      SRC_JUMP: pc_d = jump_tgt_i;
      SRC_RET:  pc_d = ret_addr_i;
      default: begin
        pc_en = 1'b0;
        pc_d  = pc_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/pcb_ret_reg.sv
module pcb_ret_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en_i,
  input  logic [ADDR_W-1:0] save_val_i,
  output logic [ADDR_W-1:0] ret_addr_o
);

  logic [ADDR_W-1:0] ret_q;
  logic [ADDR_W-1:0] ret_d;

  always_comb begin
    ret_d = save_en_i ? save_val_i : ret_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
    end else if (save_en_i) begin
      ret_q <= ret_d;
    end
  end

  assign ret_addr_o = ret_q;

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2,
  parameter int COND_W = 3,
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                jmp_i,
  input  logic [COND_W-1:0]   cond_i,
  input  logic                tgt_imm_i,
  input  logic [BYTE_W-1:0]   pair_hi_i,
  input  logic [BYTE_W-1:0]   pair_lo_i,
  input  logic [2*BYTE_W-1:0] imm_i,
  input  logic [STAT_W-1:0]   status_i,
  input  logic                ret_i,
  input  logic                hlt_i,
  output logic [BYTE_W-1:0]   pc_hi_o,
  output logic [BYTE_W-1:0]   pc_lo_o,
  output logic                halted_o
);

  localparam int PC_W = PC_BYTES * BYTE_W;

  logic            rst_int_n;
  logic            cond_hit;
  logic            live;
  logic            halt_set;
  logic            save_en;
  logic            halted_q;
  logic            halted_d;
  pc_src_e         src;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] seq_next;
  logic [PC_W-1:0] pc_w;

  pcb_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcb_cond_eval #(.COND_W(COND_W), .STAT_W(STAT_W)) cond_i_u (
    .cond_i   (cond_i),
    .status_i (status_i),
    .taken_o  (cond_hit)
  );

  assign target = tgt_imm_i ? imm_i : {pair_hi_i, pair_lo_i};
  assign live   = step_i & ~halted_q;

  // next-state selection: halt over return over jump over sequential
  always_comb begin
    src      = SRC_HOLD;
    halt_set = 1'b0;
    save_en  = 1'b0;
    if (live) begin
      if (hlt_i) begin
        halt_set = 1'b1;
      end else if (ret_i) begin
        src = SRC_RET;
      end else if (jmp_i && cond_hit) begin
        src     = SRC_JUMP;
        save_en = 1'b1;
      end else begin
        src = SRC_SEQ;
      end
    end
  end

  pcb_pc_reg #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) pc_reg_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .src_i      (src),
    .len_i      (len_i),
    .jump_tgt_i (target),
    .ret_addr_i (ret_addr),
    .pc_o       (pc_w),
    .seq_next_o (seq_next)
  );

  pcb_ret_reg #(.ADDR_W(PC_W)) ret_reg_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .save_en_i  (save_en),
    .save_val_i (seq_next),
    .ret_addr_o (ret_addr)
  );

  always_comb begin
    halted_d = halted_q | halt_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      halted_q <= 1'b0;
    end else if (halt_set) begin
      halted_q <= halted_d;
    end
  end

  assign pc_hi_o  = pc_w[PC_W-1:BYTE_W];
  assign pc_lo_o  = pc_w[BYTE_W-1:0];
  assign halted_o = halted_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(step_i) |-> $stable(pc_w) && $stable(ret_addr)); // R4

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(step_i && !halted_o && !hlt_i && !ret_i && !jmp_i)
      |-> (pc_w - $past(pc_w)) == PC_W'($past(len_i))); // R2

  AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(step_i && !halted_o && !hlt_i && !ret_i && jmp_i && cond_i == '0)
      |-> pc_w == $past(tgt_imm_i ? imm_i : {pair_hi_i, pair_lo_i})); // R6

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(step_i && !halted_o && !hlt_i && ret_i) |-> pc_w == $past(ret_addr)); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted_o |=> halted_o); // R9

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(halted_o || (step_i && hlt_i)) |-> $stable(pc_w)); // R9

endmodule

// File: tb/pc_branch_unit_tb_top.sv
module pc_branch_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 27;

  typedef struct packed {
    logic        step;
    logic [1:0]  len;
    logic        jmp;
    logic [2:0]  cond;
    logic        timm;
    logic        ret;
    logic        hlt;
    logic [7:0]  stat;
    logic [15:0] pair;
    logic [15:0] imm;
    logic [15:0] exp_pc;
    logic        exp_halt;
    logic [3:0]  req;
  } vec_t;

  // step len jmp cond timm ret hlt stat pair imm exp_pc exp_halt req
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0001, 1'b0, 4'd2},  // R2
    '{1'b1, 2'd3, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0004, 1'b0, 4'd2},
    '{1'b0, 2'd3, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'hABCD, 16'h0004, 1'b0, 4'd4},  // R4
    '{1'b1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0004, 1'b0, 4'd2},
    '{1'b1, 2'd3, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h00FE, 16'h00FE, 1'b0, 4'd6},  // R6 imm
    '{1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0100, 1'b0, 4'd2},  // carry
    '{1'b1, 2'd2, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 8'h80, 16'h1234, 16'hEEEE, 16'h1234, 1'b0, 4'd6},  // R6 pair
    '{1'b1, 2'd3, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 8'h7F, 16'h0000, 16'hEEEE, 16'h1237, 1'b0, 4'd7},  // R7
    '{1'b1, 2'd3, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 8'h40, 16'h0000, 16'h2000, 16'h2000, 1'b0, 4'd5},  // R5
    '{1'b1, 2'd1, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 8'h20, 16'h0000, 16'h3000, 16'h3000, 1'b0, 4'd5},
    '{1'b1, 2'd1, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 8'h10, 16'h0000, 16'h4000, 16'h4000, 1'b0, 4'd5},
    '{1'b1, 2'd1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 8'h08, 16'h0000, 16'h5000, 16'h5000, 1'b0, 4'd5},
    '{1'b1, 2'd1, 1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 8'h04, 16'h0000, 16'h6000, 16'h6000, 1'b0, 4'd5},
    '{1'b1, 2'd1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 8'h02, 16'h0000, 16'h7000, 16'h7000, 1'b0, 4'd5},
    '{1'b1, 2'd1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 8'hFD, 16'h0000, 16'hEEEE, 16'h7001, 1'b0, 4'd7},  // R7
    '{1'b1, 2'd2, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 8'hDF, 16'h0000, 16'hEEEE, 16'h7003, 1'b0, 4'd7},
    '{1'b1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h6001, 1'b0, 4'd8},  // R8
    '{1'b1, 2'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h9999, 16'h6001, 1'b0, 4'd10}, // R10
    '{1'b1, 2'd1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 4'd6},
    '{1'b1, 2'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd3},  // R3
    '{1'b1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h6002, 1'b0, 4'd8},
    '{1'b1, 2'd3, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'hFFFE, 16'hFFFE, 1'b0, 4'd6},
    '{1'b1, 2'd3, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0001, 1'b0, 4'd3},  // R3
    '{1'b1, 2'd1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h5555, 16'h0001, 1'b1, 4'd10}, // R10 R9
    '{1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0001, 1'b1, 4'd9},  // R9
    '{1'b1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0001, 1'b1, 4'd9},
    '{1'b1, 2'd1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h1111, 16'h0001, 1'b1, 4'd9}
  };

  logic        clk;
  logic        rst_n;
  logic        step;
  logic [1:0]  len;
  logic        jmp;
  logic [2:0]  cond;
  logic        timm;
  logic [7:0]  pair_hi;
  logic [7:0]  pair_lo;
  logic [15:0] imm;
  logic [7:0]  stat;
  logic        ret;
  logic        hlt;
  logic [7:0]  pc_hi;
  logic [7:0]  pc_lo;
  logic        halted;

  int checks = 0;
  int errors = 0;

  pc_branch_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .len_i     (len),
    .jmp_i     (jmp),
    .cond_i    (cond),
    .tgt_imm_i (timm),
    .pair_hi_i (pair_hi),
    .pair_lo_i (pair_lo),
    .imm_i     (imm),
    .status_i  (stat),
    .ret_i     (ret),
    .hlt_i     (hlt),
    .pc_hi_o   (pc_hi),
    .pc_lo_o   (pc_lo),
    .halted_o  (halted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] exp_pc, input logic exp_halt);
    checks++;
    if ({pc_hi, pc_lo} !== exp_pc || halted !== exp_halt) begin
      errors++;
      $display("FAIL %s: pc=%h exp=%h halted=%b exp=%b", tag, {pc_hi, pc_lo}, exp_pc,
               halted, exp_halt);
    end
  endtask

  task automatic idle_inputs();
    step = 1'b0; len = 2'd0; jmp = 1'b0; cond = 3'd0; timm = 1'b0;
    pair_hi = 8'h00; pair_lo = 8'h00; imm = 16'h0000; stat = 8'h00;
    ret = 1'b0; hlt = 1'b0;
  endtask

  task automatic do_step(input logic [1:0] l, input logic r);
    step = 1'b1; len = l; ret = r;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: pc=%h exp=done halted=%b exp=done", {pc_hi, pc_lo}, halted);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    step  = 1'b1;
    len   = 2'd3;
    repeat (3) @(negedge clk);
    check("R1 during reset", 16'h0000, 1'b0);
    rst_n = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 after release", 16'h0000, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step = VEC[i].step; len = VEC[i].len; jmp = VEC[i].jmp; cond = VEC[i].cond;
      timm = VEC[i].timm; ret = VEC[i].ret; hlt = VEC[i].hlt; stat = VEC[i].stat;
      {pair_hi, pair_lo} = VEC[i].pair; imm = VEC[i].imm;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_pc, VEC[i].exp_halt);
    end
    idle_inputs();

    // R1: reset clears halted state, counter and return register
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset from halt", 16'h0000, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_step(2'd2, 1'b0);
    check("R2 step after reset", 16'h0002, 1'b0);
    do_step(2'd0, 1'b1);
    check("R1 return register cleared", 16'h0000, 1'b0);

    // R4: no step with ret and hlt requested
    ret = 1'b1; hlt = 1'b1; jmp = 1'b1; imm = 16'h4321; timm = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R4 no step ignores requests", 16'h0000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule